// File: doc/BRIEF.md
# Dual 16-bit GPIO Port with Pull-ups and Change Notification

This block holds two general-purpose I/O ports of sixteen pins each, programmed through a simple register bus with combinational read data. For each port there is a 32-bit control word, a 16-bit CPU data word and a set of pins. The control word sets both the output enable and the pull-up of every pin. The level seen on each pin is a wired combination of three things: the CPU's own drive, drive from external peripherals given as continuous direction and data vectors, and the pull-ups.

Up to four attached peripheral slots watch the ports. Each slot gives one 16-bit trigger mask per port. When a bus write to a port's control or data register changes the resolved pin levels of that port, every slot whose mask overlaps the changed bits gets a one-cycle notify pulse. The current levels of both ports are always on the outputs. The block does not generate pin-change interrupts. A nonzero write to the interrupt-control register is treated as an unsupported request and sets a sticky error flag.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset, both control words, both data words and the interrupt-control word read as 0, the error flag is 0, and no notify pulse is present.
- R2: In a control word, bit 2n set makes pin n a CPU output, and bit 2n+1 set enables the pull-up on pin n.
- R3: Each pin resolves bit by bit to (cpu_out & cpu_data) | (periph_dir & periph_data) | (~(cpu_out | periph_dir) & pullup). A pin that nothing drives and that has no pull-up reads 0.
- R4: A read of a data register (port A at byte offset 0x04, port B at 0x0C) returns the resolved pin levels, not the value last written. A read of a control register (A at 0x00, B at 0x08) returns the stored word.
- R5: In the cycle after a write to a port's control or data register, notify bit i is 1 exactly when slot i's mask for that port overlaps the XOR of that port's levels before and after the write. The pulse lasts one cycle.
- R6: A port write that leaves the resolved levels unchanged produces no notify pulse.
- R7: Control registers take only 32-bit accesses (bus_wide=1). Data, interrupt-control (0x10) and status (0x14) registers take only 16-bit accesses (bus_wide=0). A write of the wrong size has no effect, and a read of the wrong size returns 0.
- R8: A 16-bit write of a nonzero value to the interrupt-control register sets the error flag (status bit 0 and err_o), which then stays set. A zero write does not set it. A 16-bit write to status with bit 0 set clears it.
- R9: A change of the peripheral drive inputs alone changes the pin outputs but never produces a notify pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pdir_a | input | 16 | Peripheral drive enables, port A |
| pdat_a | input | 16 | Peripheral drive data, port A |
| pdir_b | input | 16 | Peripheral drive enables, port B |
| pdat_b | input | 16 | Peripheral drive data, port B |
| slot_mask_a | input | 64 | Port A trigger masks, slot i in bits 16i+15:16i |
| slot_mask_b | input | 64 | Port B trigger masks, slot i in bits 16i+15:16i |
| notify_o | output | 4 | One-cycle change pulse per slot |
| pins_a_o | output | 16 | Resolved levels of port A |
| pins_b_o | output | 16 | Resolved levels of port B |
| err_o | output | 1 | Sticky unsupported-operation flag |

## Verification
Most internal state shows on the pins at once. A control bit taken from the wrong position, or a data word that is stored badly, changes pins_a_o or pins_b_o in the cycle after the write. A data readback that returns the stored word instead of the resolved level shows up on the first read of an undriven pin. A stale captured level, or a pending flag that is not cleared, shows up only on notify_o: a pulse that lasts too long, arrives without a level change, or reaches a slot with no overlapping mask bit. Each of these appears within one cycle of the write that exposes it. A corrupted error flag shows on err_o from the cycle after the offending write until software clears it.

// File: rtl/gpio_dual_port.sv
module gpio_dual_port #(
  parameter int W  = 16,
  parameter int NS = 4,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic          bus_wide,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [W-1:0]  pdir_a,
  input  logic [W-1:0]  pdat_a,
  input  logic [W-1:0]  pdir_b,
  input  logic [W-1:0]  pdat_b,
  input  logic [NS*W-1:0] slot_mask_a,
  input  logic [NS*W-1:0] slot_mask_b,
  output logic [NS-1:0] notify_o,
  output logic [W-1:0]  pins_a_o,
  output logic [W-1:0]  pins_b_o,
  output logic          err_o
);
  localparam int CW = 2 * W;
  localparam logic [AW-1:0] OFF_CTL_A = AW'(5'h00);
  localparam logic [AW-1:0] OFF_DAT_A = AW'(5'h04);
  localparam logic [AW-1:0] OFF_CTL_B = AW'(5'h08);
  localparam logic [AW-1:0] OFF_DAT_B = AW'(5'h0C);
  localparam logic [AW-1:0] OFF_IRQC  = AW'(5'h10);
  localparam logic [AW-1:0] OFF_STAT  = AW'(5'h14);

  logic [CW-1:0] ctl_a, ctl_b;
  logic [W-1:0]  dat_a, dat_b, irqc;
  logic [W-1:0]  out_a, out_b, pu_a, pu_b;
  logic [W-1:0]  lvl_a, lvl_b, prev_a, prev_b, chg_a, chg_b;
  logic          pend_a, pend_b, err;

  for (genvar n = 0; n < W; n++) begin : g_split
    assign out_a[n] = ctl_a[2*n];
    assign pu_a[n]  = ctl_a[2*n+1];
    assign out_b[n] = ctl_b[2*n];
    assign pu_b[n]  = ctl_b[2*n+1];
  end

  assign lvl_a = (out_a & dat_a) | (pdir_a & pdat_a) | (~(out_a | pdir_a) & pu_a);
  assign lvl_b = (out_b & dat_b) | (pdir_b & pdat_b) | (~(out_b | pdir_b) & pu_b);

  wire wr       = bus_en & bus_wr;
  wire rd       = bus_en & ~bus_wr;
  wire sel_ca   = (bus_addr == OFF_CTL_A) &  bus_wide;
  wire sel_cb   = (bus_addr == OFF_CTL_B) &  bus_wide;
  wire sel_da   = (bus_addr == OFF_DAT_A) & ~bus_wide;
  wire sel_db   = (bus_addr == OFF_DAT_B) & ~bus_wide;
  wire sel_irq  = (bus_addr == OFF_IRQC)  & ~bus_wide;
  wire sel_stat = (bus_addr == OFF_STAT)  & ~bus_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a  <= '0;
      ctl_b  <= '0;
      dat_a  <= '0;
      dat_b  <= '0;
      irqc   <= '0;
      err    <= 1'b0;
      pend_a <= 1'b0;
      pend_b <= 1'b0;
      prev_a <= '0;
      prev_b <= '0;
    end else begin
      prev_a <= lvl_a;
      prev_b <= lvl_b;
      pend_a <= wr & (sel_ca | sel_da);
      pend_b <= wr & (sel_cb | sel_db);
      if (wr && sel_ca) ctl_a <= bus_wdata[CW-1:0];
      if (wr && sel_cb) ctl_b <= bus_wdata[CW-1:0];
      if (wr && sel_da) dat_a <= bus_wdata[W-1:0];
      if (wr && sel_db) dat_b <= bus_wdata[W-1:0];
      if (wr && sel_irq) begin
        irqc <= bus_wdata[W-1:0];
        if (bus_wdata[W-1:0] != '0) err <= 1'b1;
      end else if (wr && sel_stat && bus_wdata[0]) begin
        err <= 1'b0;
      end
    end
  end

  assign chg_a = pend_a ? (lvl_a ^ prev_a) : '0;
  assign chg_b = pend_b ? (lvl_b ^ prev_b) : '0;

  for (genvar i = 0; i < NS; i++) begin : g_slot
    assign notify_o[i] = (|(slot_mask_a[i*W +: W] & chg_a)) |
                         (|(slot_mask_b[i*W +: W] & chg_b));
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (sel_ca)   bus_rdata = 32'(ctl_a);
      if (sel_cb)   bus_rdata = 32'(ctl_b);
      if (sel_da)   bus_rdata = 32'(lvl_a);
      if (sel_db)   bus_rdata = 32'(lvl_b);
      if (sel_irq)  bus_rdata = 32'(irqc);
      if (sel_stat) bus_rdata = {31'b0, err};
    end
  end

  assign pins_a_o = lvl_a;
  assign pins_b_o = lvl_b;
  assign err_o    = err;
endmodule

// File: rtl/gpio_dual_port_chk.sv
module gpio_dual_port_chk #(
  parameter int W  = 16,
  parameter int NS = 4,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_wr,
  input logic          bus_wide,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [W-1:0]  pdir_a,
  input logic [W-1:0]  pdat_a,
  input logic [W-1:0]  pdir_b,
  input logic [W-1:0]  pdat_b,
  input logic [NS-1:0] notify_o,
  input logic [W-1:0]  pins_a_o,
  input logic [W-1:0]  pins_b_o,
  input logic          err_o
);
  wire port_wr = bus_en && bus_wr &&
                 ((bus_wide && (bus_addr == AW'(5'h00) || bus_addr == AW'(5'h08))) ||
                  (!bus_wide && (bus_addr == AW'(5'h04) || bus_addr == AW'(5'h0C))));
  wire irq_set = bus_en && bus_wr && !bus_wide && bus_addr == AW'(5'h10) &&
                 bus_wdata[W-1:0] != '0;
  wire clr_req = bus_en && bus_wr && !bus_wide && bus_addr == AW'(5'h14) && bus_wdata[0];

  AST_NOTIFY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_o != '0) |-> $past(port_wr)); // R5

  AST_NOTIFY_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (notify_o != '0) |-> (pins_a_o != $past(pins_a_o) || pins_b_o != $past(pins_b_o))); // R6

  AST_PERIPH_HIGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pdir_a & pdat_a & ~pins_a_o) == '0) && ((pdir_b & pdat_b & ~pins_b_o) == '0)); // R3

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> err_o); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_req) |=> err_o); // R8
endmodule

bind gpio_dual_port gpio_dual_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_wide(bus_wide),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pdir_a(pdir_a), .pdat_a(pdat_a),
  .pdir_b(pdir_b), .pdat_b(pdat_b), .notify_o(notify_o), .pins_a_o(pins_a_o),
  .pins_b_o(pins_b_o), .err_o(err_o)
);

// File: tb/gpio_dual_port_bench.sv
module gpio_dual_port_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_en = 0, bus_wr = 0, bus_wide = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pdir_a = '0, pdat_a = '0, pdir_b = '0, pdat_b = '0;
  logic [63:0] slot_mask_a = '0, slot_mask_b = '0;
  logic [3:0]  notify_o;
  logic [15:0] pins_a_o, pins_b_o;
  logic        err_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_dual_port u_gpio_dual_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pdir_a(pdir_a), .pdat_a(pdat_a), .pdir_b(pdir_b), .pdat_b(pdat_b),
    .slot_mask_a(slot_mask_a), .slot_mask_b(slot_mask_b), .notify_o(notify_o),
    .pins_a_o(pins_a_o), .pins_b_o(pins_b_o), .err_o(err_o)
  );

  // {control, data, periph dir, periph data, expected level}
  localparam logic [95:0] VEC [6] = '{
    {32'h00000000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000},
    {32'h55555555, 16'hA5A5, 16'h0000, 16'h0000, 16'hA5A5},
    {32'hAAAAAAAA, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF},
    {32'hAAAAAAAA, 16'h0000, 16'h00FF, 16'h000F, 16'hFF0F},
    {32'h0000FFFF, 16'h3C3C, 16'h0000, 16'h0000, 16'h003C},
    {32'h00000005, 16'h0001, 16'hFF00, 16'h1200, 16'h1201}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [4:0] a, input logic wide, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [4:0] a, input logic wide, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_wide = wide; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bread(5'h00, 1, r); check("R1 ctl A", r, 0);
    bread(5'h08, 1, r); check("R1 ctl B", r, 0);
    bread(5'h04, 0, r); check("R1 data A", r, 0);
    bread(5'h10, 0, r); check("R1 irq ctl", r, 0);
    check("R1 err", {31'b0, err_o}, 0);
    check("R1 notify", {28'b0, notify_o}, 0);

    // R5 / R6 notifications
    slot_mask_a = {16'hFFFF, 16'h0000, 16'h0100, 16'h0001};
    slot_mask_b = {16'h0000, 16'h0001, 16'h0000, 16'h0000};
    bwrite(5'h00, 1, 32'h55555555);
    check("R6 ctl write no change", {28'b0, notify_o}, 0);
    bwrite(5'h04, 0, 32'h0001);
    check("R5 pin0 A slots 0,3", {28'b0, notify_o}, 32'h9);
    @(negedge clk);
    check("R5 pulse one cycle", {28'b0, notify_o}, 0);
    bwrite(5'h04, 0, 32'h0001);
    check("R6 same data", {28'b0, notify_o}, 0);
    bwrite(5'h04, 0, 32'h0101);
    check("R5 pin8 A slots 1,3", {28'b0, notify_o}, 32'hA);
    bwrite(5'h0C, 0, 32'h0001);
    check("R6 B input pin", {28'b0, notify_o}, 0);
    bwrite(5'h08, 1, 32'h00000001);
    check("R5 B pin0 via ctl", {28'b0, notify_o}, 32'h4);

    // R9 peripheral changes alone
    @(negedge clk);
    pdir_a = 16'h0200; pdat_a = 16'h0200;
    #1 check("R9 pins follow periph", {16'b0, pins_a_o}, 32'h0301);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 no notify", {28'b0, notify_o}, 0);
    end
    pdir_a = 0; pdat_a = 0;
    slot_mask_a = '0; slot_mask_b = '0;

    // R2 / R3 / R4 vector table on both ports
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 6; k++) begin
        logic [4:0] ca, da;
        ca = p == 0 ? 5'h00 : 5'h08;
        da = p == 0 ? 5'h04 : 5'h0C;
        if (p == 0) begin pdir_a = VEC[k][47:32]; pdat_a = VEC[k][31:16]; end
        else        begin pdir_b = VEC[k][47:32]; pdat_b = VEC[k][31:16]; end
        bwrite(ca, 1, VEC[k][95:64]);
        bwrite(da, 0, {16'b0, VEC[k][63:48]});
        bread(da, 0, r);
        check("R2 R3 R4 resolved level", r, {16'b0, VEC[k][15:0]});
      end
    end
    pdir_a = 0; pdat_a = 0; pdir_b = 0; pdat_b = 0;

    // R7 wrong-size accesses
    bwrite(5'h00, 1, 32'h55555555);
    bwrite(5'h04, 0, 32'h1234);
    bwrite(5'h04, 1, 32'h0000FFFF);
    bread(5'h04, 0, r); check("R7 wide data write ignored", r, 32'h1234);
    bwrite(5'h00, 0, 32'h0);
    bread(5'h00, 1, r); check("R7 narrow ctl write ignored", r, 32'h55555555);
    bread(5'h00, 0, r); check("R7 narrow ctl read zero", r, 0);
    bread(5'h04, 1, r); check("R7 wide data read zero", r, 0);

    // R8 sticky error
    bwrite(5'h10, 0, 32'h0);
    check("R8 zero write no error", {31'b0, err_o}, 0);
    bwrite(5'h10, 0, 32'h0005);
    check("R8 nonzero sets error", {31'b0, err_o}, 1);
    bwrite(5'h14, 0, 32'h0);
    bread(5'h14, 0, r); check("R8 sticky", r, 1);
    bwrite(5'h14, 0, 32'h1);
    bread(5'h14, 0, r); check("R8 cleared", r, 0);
    check("R8 err_o cleared", {31'b0, err_o}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule